// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block turns processor writes into the cartridge's read-only address range into bank selections for an external memory mapper. Nothing is ever read back. The top three address bits pick one of four control regions. These regions hold a RAM gate, a low ROM bank field, a two-bit upper field and a banking mode bit. From that state the block produces the physical ROM bank for the fixed lower window and for the switchable upper window. It also produces the external RAM bank and the RAM enable.

A strap input narrows the low bank field from five bits to four. Multi-game carts need this, because they place each game in a sixteen-bank slice. The ROM size is set by a parameter. Any bank number beyond it wraps onto the banks that exist.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the switchable bank is 1, the fixed bank is 0, the RAM bank is 0, RAM is disabled and the mode is 0.
- R2: Address bits [15:13] select the region. Regions 0 to 3 are decoded. A write with region 4 to 7 changes no output.
- R3: A region 0 write of 0x0A sets the RAM enable and a write of 0x00 clears it. Any other value leaves the enable as it was.
- R4: A region 1 write takes data bits [4:0] as the low field. If those bits are zero, the value 1 is stored in their place, and this happens before any further masking.
- R5: The low field is masked to 5 bits when multi_game is 0 and to 4 bits when it is 1 (the stride). Before wrapping, the switchable bank is (upper << stride) | masked low.
- R6: A region 2 write stores data bits [1:0] as the upper field. When the mode is 1, the same write also sets the RAM bank to those bits.
- R7: A region 3 write sets the mode to data bit 0. In mode 1 the fixed bank is (upper << stride). Entering mode 1 leaves the RAM bank unchanged. Writing mode 0 forces the fixed bank to 0 and the RAM bank to 0.
- R8: Both ROM banks are masked with ROM_BANKS-1. A switchable result of 0 after masking is replaced by 1. A fixed result of 0 stays 0.
- R9: A write sampled at clock edge E updates the control state at E. The outputs show the change after edge E+1 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 16 | Write address; bits [15:13] pick the region |
| wr_data | input | 8 | Write data |
| multi_game | input | 1 | Strap: 1 selects the 4-bit low field |
| fixed_bank | output | $clog2(ROM_BANKS) | Physical bank for the fixed window |
| switch_bank | output | $clog2(ROM_BANKS) | Physical bank for the switchable window |
| ram_bank | output | 2 | External RAM bank |
| ram_en | output | 1 | External RAM enable |

## Verification
The bench builds two copies of the block and drives them with the same writes. One copy uses 128 banks, where the seven-bit result exactly fills the bank number, so every upper-field and stride combination can be seen without loss. The other uses 16 banks, where the upper field shifted by either stride is masked away. That copy brings the wrap-to-zero promotion and the fixed bank wrapping to 0 in mode 1 within reach.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

   // width of the region selector at the top of the address
   localparam int RGN_W = 3;

   localparam logic [RGN_W-1:0] RGN_RAM_GATE  = 3'd0;
   localparam logic [RGN_W-1:0] RGN_LOW_SEL   = 3'd1;
   localparam logic [RGN_W-1:0] RGN_UPPER_SEL = 3'd2;
   localparam logic [RGN_W-1:0] RGN_MODE_SEL  = 3'd3;

   localparam logic [7:0] RAM_KEY_ON  = 8'h0A;
   localparam logic [7:0] RAM_KEY_OFF = 8'h00;

endpackage

// File: rtl/cart_ctrl_regs.sv
module cart_ctrl_regs
   import cart_bank_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int LOW_W   = 5,
   parameter int UPPER_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               ram_en_q,
   output logic               mode_q,
   output logic [LOW_W-1:0]   low_q,
   output logic [UPPER_W-1:0] upper_q,
   output logic [UPPER_W-1:0] ram_bank_q
);

   localparam int SEL_LSB = ADDR_W - RGN_W;

   logic [RGN_W-1:0]   region;
   logic [LOW_W-1:0]   low_in;
   logic [LOW_W-1:0]   low_promoted;
   logic [UPPER_W-1:0] upper_in;
   logic               unused_addr;

   assign region       = wr_addr[ADDR_W-1:SEL_LSB];
   assign low_in       = wr_data[LOW_W-1:0];
   assign low_promoted = (low_in == '0) ? LOW_W'(1) : low_in;
   assign upper_in     = wr_data[UPPER_W-1:0];
   assign unused_addr  = ^wr_addr[SEL_LSB-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ram_en_q   <= 1'b0;
         mode_q     <= 1'b0;
         low_q      <= LOW_W'(1);
         upper_q    <= '0;
         ram_bank_q <= '0;
      end else if (wr_en) begin
         case (region)
            RGN_RAM_GATE: begin
               if (wr_data == DATA_W'(RAM_KEY_ON))
                  ram_en_q <= 1'b1;
               else if (wr_data == DATA_W'(RAM_KEY_OFF))
                  ram_en_q <= 1'b0;
            end
            RGN_LOW_SEL: begin
               low_q <= low_promoted;
            end
            RGN_UPPER_SEL: begin
               upper_q <= upper_in;
               if (mode_q)
                  ram_bank_q <= upper_in;
            end
            RGN_MODE_SEL: begin
               mode_q <= wr_data[0];
               if (!wr_data[0])
                  ram_bank_q <= '0;
            end
            default: begin
            end
         endcase
      end
   end

endmodule

// File: rtl/cart_bank_map.sv
module cart_bank_map #(
   parameter int ROM_BANKS   = 128,
   parameter int LOW_W       = 5,
   parameter int MULTI_LOW_W = 4,
   parameter int UPPER_W     = 2,
   localparam int BANK_W     = $clog2(ROM_BANKS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               multi_game,
   input  logic [LOW_W-1:0]   low_q,
   input  logic [UPPER_W-1:0] upper_q,
   input  logic               mode_q,
   input  logic               ram_en_q,
   input  logic [UPPER_W-1:0] ram_bank_q,
   output logic [BANK_W-1:0]  fixed_bank,
   output logic [BANK_W-1:0]  switch_bank,
   output logic [UPPER_W-1:0] ram_bank,
   output logic               ram_en
);

   localparam int RAW_W = LOW_W + UPPER_W;
   localparam int PAD_W = LOW_W - MULTI_LOW_W;

   logic [RAW_W-1:0]  sw_norm, sw_multi, sw_raw;
   logic [RAW_W-1:0]  fx_norm, fx_multi, fx_raw;
   logic [BANK_W-1:0] sw_fit, fx_fit;
   logic [BANK_W-1:0] sw_next, fx_next;

   // stride 5: upper bits sit directly above the full low field
   assign sw_norm  = {upper_q, low_q};
   assign fx_norm  = {upper_q, {LOW_W{1'b0}}};
   // stride 4: the top low bit is dropped and upper moves down by one
   assign sw_multi = {{PAD_W{1'b0}}, upper_q, low_q[MULTI_LOW_W-1:0]};
   assign fx_multi = {{PAD_W{1'b0}}, upper_q, {MULTI_LOW_W{1'b0}}};

   assign sw_raw = multi_game ? sw_multi : sw_norm;
   assign fx_raw = multi_game ? fx_multi : fx_norm;

   // fit the raw bank number to the ROM: widen, pass or wrap
   generate
      if (BANK_W > RAW_W) begin : g_widen
         assign sw_fit = {{(BANK_W-RAW_W){1'b0}}, sw_raw};
         assign fx_fit = {{(BANK_W-RAW_W){1'b0}}, fx_raw};
      end else if (BANK_W == RAW_W) begin : g_exact
         assign sw_fit = sw_raw;
         assign fx_fit = fx_raw;
      end else begin : g_wrap
         logic unused_hi;
         assign sw_fit    = sw_raw[BANK_W-1:0];
         assign fx_fit    = fx_raw[BANK_W-1:0];
         assign unused_hi = ^{sw_raw[RAW_W-1:BANK_W], fx_raw[RAW_W-1:BANK_W]};
      end
   endgenerate

   assign sw_next = (sw_fit == '0) ? BANK_W'(1) : sw_fit;
   assign fx_next = mode_q ? fx_fit : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         switch_bank <= BANK_W'(1);
         fixed_bank  <= '0;
         ram_bank    <= '0;
         ram_en      <= 1'b0;
      end else begin
         switch_bank <= sw_next;
         fixed_bank  <= fx_next;
         ram_bank    <= ram_bank_q;
         ram_en      <= ram_en_q;
      end
   end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
   parameter int ROM_BANKS   = 128,
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int LOW_W       = 5,
   parameter int MULTI_LOW_W = 4,
   parameter int UPPER_W     = 2,
   localparam int BANK_W     = $clog2(ROM_BANKS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               multi_game,
   output logic [BANK_W-1:0]  fixed_bank,
   output logic [BANK_W-1:0]  switch_bank,
   output logic [UPPER_W-1:0] ram_bank,
   output logic               ram_en
);

   generate
      if (ROM_BANKS < 2 || (ROM_BANKS & (ROM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("ROM_BANKS must be a power of two of at least 2");
      end
      if (MULTI_LOW_W < 1 || MULTI_LOW_W >= LOW_W) begin : g_bad_multi
         $error("MULTI_LOW_W must be between 1 and LOW_W-1");
      end
      if (LOW_W > DATA_W || UPPER_W > DATA_W) begin : g_bad_fields
         $error("bank fields must fit in the data bus");
      end
      if (ADDR_W <= cart_bank_pkg::RGN_W) begin : g_bad_addr
         $error("ADDR_W must exceed the region selector width");
      end
   endgenerate

   logic               ram_en_q;
   logic               mode_q;
   logic [LOW_W-1:0]   low_q;
   logic [UPPER_W-1:0] upper_q;
   logic [UPPER_W-1:0] ram_bank_q;

   cart_ctrl_regs #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .LOW_W   (LOW_W),
      .UPPER_W (UPPER_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .ram_en_q   (ram_en_q),
      .mode_q     (mode_q),
      .low_q      (low_q),
      .upper_q    (upper_q),
      .ram_bank_q (ram_bank_q)
   );

   cart_bank_map #(
      .ROM_BANKS   (ROM_BANKS),
      .LOW_W       (LOW_W),
      .MULTI_LOW_W (MULTI_LOW_W),
      .UPPER_W     (UPPER_W)
   ) u_map (
      .clk         (clk),
      .rst_n       (rst_n),
      .multi_game  (multi_game),
      .low_q       (low_q),
      .upper_q     (upper_q),
      .mode_q      (mode_q),
      .ram_en_q    (ram_en_q),
      .ram_bank_q  (ram_bank_q),
      .fixed_bank  (fixed_bank),
      .switch_bank (switch_bank),
      .ram_bank    (ram_bank),
      .ram_en      (ram_en)
   );

endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk #(
   parameter int ROM_BANKS = 128,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int UPPER_W   = 2,
   localparam int BANK_W   = $clog2(ROM_BANKS)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [DATA_W-1:0]  wr_data,
   input logic               multi_game,
   input logic [BANK_W-1:0]  fixed_bank,
   input logic [BANK_W-1:0]  switch_bank,
   input logic [UPPER_W-1:0] ram_bank,
   input logic               ram_en
);

   logic [2:0] rgn;
   logic       wr_gate_on, wr_gate_off, wr_gate_other, wr_mode_clr, wr_live;
   logic       unused_low;

   assign rgn           = wr_addr[ADDR_W-1 -: 3];
   assign unused_low    = ^wr_addr[ADDR_W-4:0];
   assign wr_gate_on    = wr_en && rgn == 3'd0 && wr_data == DATA_W'(8'h0A);
   assign wr_gate_off   = wr_en && rgn == 3'd0 && wr_data == '0;
   assign wr_gate_other = wr_en && rgn == 3'd0 && !wr_gate_on && !wr_gate_off;
   assign wr_mode_clr   = wr_en && rgn == 3'd3 && !wr_data[0];
   assign wr_live       = wr_en && rgn < 3'd4;

   AST_SWITCH_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      switch_bank != '0);                                                    // R8

   AST_GATE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_gate_on, 2) |-> ram_en);                                      // R3

   AST_GATE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_gate_off, 2) |-> !ram_en);                                    // R3

   AST_GATE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_gate_other, 2) |-> $stable(ram_en));                          // R3

   AST_MODE_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_mode_clr, 2) |-> (fixed_bank == '0 && ram_bank == '0));       // R7

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_live, 2) && $past(multi_game, 1) == $past(multi_game, 2))
      |-> ($stable(switch_bank) && $stable(fixed_bank)
           && $stable(ram_bank) && $stable(ram_en)));                        // R2

endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(
   .ROM_BANKS (ROM_BANKS),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .UPPER_W   (UPPER_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .multi_game  (multi_game),
   .fixed_bank  (fixed_bank),
   .switch_bank (switch_bank),
   .ram_bank    (ram_bank),
   .ram_en      (ram_en)
);

// File: tb/cart_bank_ctrl_bench.sv
`timescale 1ns/1ps
module cart_bank_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        multi_game = 1'b0;

   logic [6:0] big_fixed, big_switch;
   logic [1:0] big_ram_bank;
   logic       big_ram_en;
   logic [3:0] sml_fixed, sml_switch;
   logic [1:0] sml_ram_bank;
   logic       sml_ram_en;

   int checks = 0;
   int fails  = 0;

   // model state
   int unsigned m_low = 1, m_up = 0, m_mode = 0, m_en = 0, m_rb = 0;

   always #2.5 clk = ~clk;

   cart_bank_ctrl #(.ROM_BANKS(128)) u_cart_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .multi_game(multi_game),
      .fixed_bank(big_fixed), .switch_bank(big_switch),
      .ram_bank(big_ram_bank), .ram_en(big_ram_en));

   cart_bank_ctrl #(.ROM_BANKS(16)) u_cart_bank_ctrl_small (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .multi_game(multi_game),
      .fixed_bank(sml_fixed), .switch_bank(sml_switch),
      .ram_bank(sml_ram_bank), .ram_en(sml_ram_en));

   function automatic int unsigned exp_switch(int unsigned banks, bit strap);
      int unsigned v;
      v = strap ? ((m_up << 4) | (m_low & 15)) : ((m_up << 5) | (m_low & 31));
      v = v & (banks - 1);
      if (v == 0) v = 1;
      return v;
   endfunction

   function automatic int unsigned exp_fixed(int unsigned banks, bit strap);
      if (m_mode == 0) return 0;
      return (m_up << (strap ? 4 : 5)) & (banks - 1);
   endfunction

   task automatic chk(string req, string what, int unsigned act, int unsigned exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(string req);
      chk(req, "big switch", big_switch, exp_switch(128, multi_game));
      chk(req, "big fixed", big_fixed, exp_fixed(128, multi_game));
      chk(req, "big ram_bank", big_ram_bank, m_rb);
      chk(req, "big ram_en", big_ram_en, m_en);
      chk(req, "small switch", sml_switch, exp_switch(16, multi_game));
      chk(req, "small fixed", sml_fixed, exp_fixed(16, multi_game));
      chk(req, "small ram_bank", sml_ram_bank, m_rb);
      chk(req, "small ram_en", sml_ram_en, m_en);
   endtask

   function automatic void model_write(int unsigned rgn, int unsigned d);
      case (rgn)
         0: begin
            if (d == 8'h0A) m_en = 1;
            else if (d == 0) m_en = 0;
         end
         1: m_low = ((d & 31) == 0) ? 1 : (d & 31);
         2: begin
            m_up = d & 3;
            if (m_mode == 1) m_rb = d & 3;
         end
         3: begin
            m_mode = d & 1;
            if (m_mode == 0) m_rb = 0;
         end
         default: ;
      endcase
   endfunction

   // one write; returns after edge E (state updated, outputs not yet)
   task automatic issue(int unsigned rgn, int unsigned d);
      @(negedge clk);
      wr_addr = {rgn[2:0], 13'($urandom)};
      wr_data = d[7:0];
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
      model_write(rgn, d);
   endtask

   task automatic wr_check(int unsigned rgn, int unsigned d, string req);
      issue(rgn, d);
      @(negedge clk);
      check_all(req);
   endtask

   task automatic set_strap(bit s, string req);
      @(negedge clk);
      multi_game = s;
      @(negedge clk);
      @(negedge clk);
      check_all(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240607));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R3: RAM gate keys
      wr_check(0, 8'h0A, "R3");
      wr_check(0, 8'h55, "R3");
      wr_check(0, 8'h0B, "R3");
      wr_check(0, 8'h00, "R3");
      wr_check(0, 8'h8A, "R3");

      // R4: zero promoted, and promotion precedes masking
      wr_check(1, 8'h00, "R4");
      wr_check(1, 8'hE0, "R4");
      wr_check(1, 8'h13, "R4");

      // R5: multi-game stride masks bit 4 away
      wr_check(1, 8'h10, "R5");
      set_strap(1'b1, "R5");
      wr_check(2, 8'h02, "R5");
      set_strap(1'b0, "R5");

      // R9: latency, old value after E, new after E+1
      wr_check(2, 8'h00, "R9");
      wr_check(1, 8'h05, "R9");
      issue(1, 8'h07);
      chk("R9", "switch before E+1", big_switch, 5);
      @(negedge clk);
      chk("R9", "switch after E+1", big_switch, 7);

      // R6/R7: mode sequences
      wr_check(2, 8'h03, "R6");
      wr_check(3, 8'h01, "R7");
      chk("R7", "ram bank kept on mode set", big_ram_bank, 0);
      wr_check(2, 8'h02, "R6");
      wr_check(2, 8'hFD, "R6");
      wr_check(3, 8'h00, "R7");
      wr_check(2, 8'h03, "R6");

      // R8: small ROM wraps; 0x10 with upper 0 wraps to 0 then becomes 1
      wr_check(2, 8'h00, "R8");
      wr_check(1, 8'h10, "R8");
      chk("R8", "small wrap promote", sml_switch, 1);
      wr_check(3, 8'h01, "R8");
      wr_check(2, 8'h01, "R8");
      chk("R8", "small fixed wraps to 0", sml_fixed, 0);

      // R2: ignored regions
      for (int r = 4; r < 8; r++) wr_check(r, 8'h0A, "R2");
      wr_check(5, 8'h00, "R2");

      // random mix
      for (int i = 0; i < 800; i++) begin
         int unsigned rgn, d, pick;
         string tag;
         if (($urandom % 16) == 0) set_strap(($urandom % 2) == 1, "R5");
         rgn  = $urandom % 8;
         pick = $urandom % 4;
         d    = (pick == 0) ? 0 : (pick == 1) ? 8'h0A : ($urandom % 256);
         case (rgn)
            0: tag = "R3";
            1: tag = "R4";
            2: tag = "R6";
            3: tag = "R7";
            default: tag = "R2";
         endcase
         wr_check(rgn, d, tag);
      end

      // reset returns to initial state
      @(negedge clk);
      rst_n = 1'b0;
      m_low = 1; m_up = 0; m_mode = 0; m_en = 0; m_rb = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_all("R1");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule